// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside a byte-wide non-volatile memory and watches every host write cycle (address and data) that reaches it. It recognises multi-write unlock sequences that all begin with the same two-write prefix. From them it keeps a software write-protection state and raises a start pulse for a chip erase. It also enters or leaves an identification read mode.

The page-write engine consults `load_ok` on each write to decide whether the byte goes into its page buffer. The erase timer consumes `erase_start`. Reads pass through the block, which replaces array data with fixed identification codes while `id_mode` is set. Writes that the decoder consumes as command steps are never passed on as page data. Address matching uses only the low 15 address bits. Key addresses are 5555h ("K1") and 2AAAh ("K2").

Top module: `cmd_seq_decoder`

## Requirements
- R1: After reset `prot_en` is 1, `id_mode` is 0 and `erase_start` is 0.
- R2: While `prot_en` is 1 and no unlock is open, a data write gives `load_ok` = 0.
- R3: The writes AAh@K1, 55h@K2, A0h@K1 open a load window and set `prot_en`. Later data writes give `load_ok` = 1 in the same cycle as `wr_en`.
- R4: A write consumed as a sequence step never gives `load_ok` = 1.
- R5: The writes AAh@K1, 55h@K2, 80h@K1, AAh@K1, 55h@K2, 10h@K1 make `erase_start` high for exactly one cycle, the cycle after the final write.
- R6: The writes AAh@K1, 55h@K2, 80h@K1, AAh@K1, 55h@K2, 60h@K1 set `id_mode` in the cycle after the final write. While `id_mode` is set, `rd_data` is DAh for `rd_addr` 0, C1h for `rd_addr` 1, and 00h for any other address.
- R7: The writes AAh@K1, 55h@K2, F0h@K1 clear `id_mode`. After that, `rd_data` follows `arr_rdata`.
- R8: Only `wr_addr[14:0]` is compared, so key writes with bit 16 set still match.
- R9: A write that breaks a sequence returns the matcher to idle. That same write is then checked again as a possible first step, AAh@K1.
- R10: The writes AAh@K1, 55h@K2, 80h@K1, AAh@K1, 55h@K2, 20h@K1 clear `prot_en`. While `prot_en` is 0, every data write gives `load_ok` = 1.
- R11: A `page_done` pulse closes the load window. The next data write under protection gives `load_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host write cycle strobe, one cycle per write |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| page_done | input | 1 | Page load finished pulse from the page-write engine |
| rd_addr | input | 17 | Read address |
| arr_rdata | input | 8 | Read data from the array |
| rd_data | output | 8 | Read data to the host |
| load_ok | output | 1 | The current write may enter the page buffer |
| erase_start | output | 1 | One-cycle chip-erase start pulse |
| id_mode | output | 1 | Identification read mode active |
| prot_en | output | 1 | Software write protection enabled |

## Verification
The hardest case to reach is a broken sequence that is recovered. The host writes AAh@K1 and 55h@K2, then sends AAh@K1 where a command byte was expected. The decoder must drop the partial match and also count that third write as a fresh first step, so the sequence must then complete with only 55h@K2 and A0h@K1. The stimulus table contains exactly this interleaving. It also replays the unlock with address bit 16 set. It closes the window with `page_done` between groups, so each window is seen to open and close at the write-permit output.

// File: rtl/cmd_seq_decoder.sv
module cmd_seq_decoder #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CMP_W  = 15,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'hDA,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'hC1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              page_done,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              load_ok,
  output logic              erase_start,
  output logic              id_mode,
  output logic              prot_en
);
  localparam logic [CMP_W-1:0]  KEY1   = CMP_W'(15'h5555);
  localparam logic [CMP_W-1:0]  KEY2   = CMP_W'(15'h2AAA);
  localparam logic [DATA_W-1:0] C_AA   = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] C_55   = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] C_UNLK = DATA_W'(8'hA0);
  localparam logic [DATA_W-1:0] C_EXT  = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] C_EXIT = DATA_W'(8'hF0);
  localparam logic [DATA_W-1:0] C_ERAS = DATA_W'(8'h10);
  localparam logic [DATA_W-1:0] C_IDEN = DATA_W'(8'h60);
  localparam logic [DATA_W-1:0] C_UNPR = DATA_W'(8'h20);

  typedef enum logic [2:0] {IDLE, P1, P2, X1, X2, X3} seq_t;
  seq_t st, nxt;

  logic win;
  logic consumed, do_unlock, do_exit, do_erase, do_entry, do_unprot;

  wire at_k1  = wr_addr[CMP_W-1:0] == KEY1;
  wire at_k2  = wr_addr[CMP_W-1:0] == KEY2;
  wire first  = wr_en && at_k1 && wr_data == C_AA;
  wire second = wr_en && at_k2 && wr_data == C_55;
  wire cmd    = wr_en && at_k1;

  always_comb begin
    nxt       = st;
    consumed  = 1'b0;
    do_unlock = 1'b0;
    do_exit   = 1'b0;
    do_erase  = 1'b0;
    do_entry  = 1'b0;
    do_unprot = 1'b0;
    if (wr_en) begin
      case (st)
        IDLE: if (first)  begin nxt = P1; consumed = 1'b1; end
        P1:   if (second) begin nxt = P2; consumed = 1'b1; end
        P2: begin
          if (cmd && wr_data == C_UNLK) begin nxt = IDLE; consumed = 1'b1; do_unlock = 1'b1; end
          else if (cmd && wr_data == C_EXIT) begin nxt = IDLE; consumed = 1'b1; do_exit = 1'b1; end
          else if (cmd && wr_data == C_EXT) begin nxt = X1; consumed = 1'b1; end
        end
        X1:   if (first)  begin nxt = X2; consumed = 1'b1; end
        X2:   if (second) begin nxt = X3; consumed = 1'b1; end
        X3: begin
          if (cmd && wr_data == C_ERAS) begin nxt = IDLE; consumed = 1'b1; do_erase = 1'b1; end
          else if (cmd && wr_data == C_IDEN) begin nxt = IDLE; consumed = 1'b1; do_entry = 1'b1; end
          else if (cmd && wr_data == C_UNPR) begin nxt = IDLE; consumed = 1'b1; do_unprot = 1'b1; end
        end
        default: nxt = IDLE;
      endcase
      if (!consumed) begin
        nxt      = first ? P1 : IDLE;
        consumed = first;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      win         <= 1'b0;
      prot_en     <= 1'b1;
      id_mode     <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      st          <= nxt;
      erase_start <= do_erase;
      if (do_unlock)      win <= 1'b1;
      else if (page_done) win <= 1'b0;
      if (do_unlock)      prot_en <= 1'b1;
      else if (do_unprot) prot_en <= 1'b0;
      if (do_entry)       id_mode <= 1'b1;
      else if (do_exit)   id_mode <= 1'b0;
    end
  end

  assign load_ok = wr_en && !consumed && (!prot_en || win);

  always_comb begin
    if (!id_mode)                  rd_data = arr_rdata;
    else if (rd_addr == ADDR_W'(0)) rd_data = MFR_CODE;
    else if (rd_addr == ADDR_W'(1)) rd_data = DEV_CODE;
    else                            rd_data = '0;
  end
endmodule

// File: rtl/cmd_seq_decoder_chk.sv
module cmd_seq_decoder_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              load_ok,
  input logic              erase_start,
  input logic              id_mode,
  input logic              prot_en
);
  assert_erase_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);
  assert_erase_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> $past(wr_en && wr_data == DATA_W'(8'h10)));
  assert_id_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(wr_en && wr_data == DATA_W'(8'h60)));
  assert_id_leave_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> $past(wr_en && wr_data == DATA_W'(8'hF0)));
  assert_unprot_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_en) |-> $past(wr_en && wr_data == DATA_W'(8'h20)));
  assert_load_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |-> wr_en);
endmodule

bind cmd_seq_decoder cmd_seq_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .load_ok(load_ok), .erase_start(erase_start), .id_mode(id_mode), .prot_en(prot_en)
);

// File: tb/sim_cmd_seq_decoder.sv
module sim_cmd_seq_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, page_done = 1'b0;
  logic [16:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, arr_rdata = 8'h5A;
  logic [7:0] rd_data;
  logic load_ok, erase_start, id_mode, prot_en;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmd_seq_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .page_done(page_done), .rd_addr(rd_addr), .arr_rdata(arr_rdata), .rd_data(rd_data),
    .load_ok(load_ok), .erase_start(erase_start), .id_mode(id_mode), .prot_en(prot_en)
  );

  // {page_done_step, expected load_ok, address, data}
  localparam int NV = 22;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 1'b0, 17'h00100, 8'h12},  // R2 protected, no unlock
    {1'b0, 1'b0, 17'h05555, 8'hAA},  // R4 steps consumed
    {1'b0, 1'b0, 17'h02AAA, 8'h55},
    {1'b0, 1'b0, 17'h05555, 8'hA0},
    {1'b0, 1'b1, 17'h00100, 8'h34},  // R3 window open
    {1'b0, 1'b1, 17'h00101, 8'h35},  // R3
    {1'b1, 1'b0, 17'h00000, 8'h00},
    {1'b0, 1'b0, 17'h00102, 8'h36},  // R11 window closed
    {1'b0, 1'b0, 17'h15555, 8'hAA},  // R8 bit 16 ignored
    {1'b0, 1'b0, 17'h12AAA, 8'h55},
    {1'b0, 1'b0, 17'h15555, 8'hA0},
    {1'b0, 1'b1, 17'h00103, 8'h37},  // R8
    {1'b1, 1'b0, 17'h00000, 8'h00},
    {1'b0, 1'b0, 17'h05555, 8'hAA},  // R9
    {1'b0, 1'b0, 17'h02AAA, 8'h55},
    {1'b0, 1'b0, 17'h05555, 8'hAA},  // R9 breaks, rechecked as first step
    {1'b0, 1'b0, 17'h02AAA, 8'h55},
    {1'b0, 1'b0, 17'h05555, 8'hA0},
    {1'b0, 1'b1, 17'h00104, 8'h38},  // R9
    {1'b1, 1'b0, 17'h00000, 8'h00},
    {1'b0, 1'b0, 17'h05555, 8'hAA},
    {1'b0, 1'b0, 17'h00200, 8'h99}   // R9 break write is protected data
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input logic exp, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1 chk(req, {7'd0, load_ok}, {7'd0, exp});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr6(input logic [7:0] last);
    wr(17'h05555, 8'hAA, 1'b0, "R4");
    wr(17'h02AAA, 8'h55, 1'b0, "R4");
    wr(17'h05555, 8'h80, 1'b0, "R4");
    wr(17'h05555, 8'hAA, 1'b0, "R4");
    wr(17'h02AAA, 8'h55, 1'b0, "R4");
    wr(17'h05555, last, 1'b0, "R4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 prot", {7'd0, prot_en}, 8'd1);
    chk("R1 id", {7'd0, id_mode}, 8'd0);
    chk("R1 erase", {7'd0, erase_start}, 8'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][26]) begin
        @(negedge clk); page_done = 1'b1;
        @(negedge clk); page_done = 1'b0;
      end else begin
        wr(VEC[i][24:8], VEC[i][7:0], VEC[i][25], $sformatf("R2/R3/R8/R9/R11 vec%0d", i));
      end
    end

    wr6(8'h10);
    chk("R5 pulse", {7'd0, erase_start}, 8'd1);
    @(negedge clk);
    chk("R5 single", {7'd0, erase_start}, 8'd0);

    rd_addr = 17'd0;
    chk("R7 pass", rd_data, 8'h5A);
    wr6(8'h60);
    chk("R6 mode", {7'd0, id_mode}, 8'd1);
    #1 chk("R6 mfr", rd_data, 8'hDA);
    rd_addr = 17'd1; #1 chk("R6 dev", rd_data, 8'hC1);
    rd_addr = 17'd7; #1 chk("R6 other", rd_data, 8'h00);
    wr(17'h05555, 8'hAA, 1'b0, "R4");
    wr(17'h02AAA, 8'h55, 1'b0, "R4");
    wr(17'h05555, 8'hF0, 1'b0, "R4");
    chk("R7 mode", {7'd0, id_mode}, 8'd0);
    rd_addr = 17'd0; arr_rdata = 8'h3C;
    #1 chk("R7 data", rd_data, 8'h3C);

    wr6(8'h20);
    chk("R10 prot", {7'd0, prot_en}, 8'd0);
    wr(17'h00300, 8'h11, 1'b1, "R10 free write");
    wr(17'h05555, 8'hAA, 1'b0, "R4 step while unprotected");
    wr(17'h00301, 8'h12, 1'b1, "R10 free write");
    wr(17'h05555, 8'hAA, 1'b0, "R3");
    wr(17'h02AAA, 8'h55, 1'b0, "R3");
    wr(17'h05555, 8'hA0, 1'b0, "R3");
    chk("R3 reprotect", {7'd0, prot_en}, 8'd1);

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 id after reset", {7'd0, id_mode}, 8'd0);
    rst_n = 1'b1;
    wr(17'h00400, 8'h01, 1'b0, "R1 window closed by reset");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule